// File: doc/BRIEF.md
# Palette and Overlay Color Selector

This block chooses the color of each pixel in a display pipeline. An 8-bit pixel index addresses a 256-entry color palette, and a 2-bit overlay code can replace the palette lookup with one of four overlay color registers. A command bit sets the meaning of overlay code 00. When the bit is 1, code 00 uses the palette. When the bit is 0, code 00 uses overlay register 0. Codes 01, 10 and 11 always use overlay registers 1, 2 and 3.

Blanking takes priority over everything else and forces the color word to zero. Sync changes no color data. It is carried to the output as a separate flag. All outputs leave the block one clock after their inputs and stay aligned with each other. A simple host write port loads palette entries and overlay registers.

Top module: `pixsel_top`

## Requirements
- R1: With the command bit at 1 and overlay code 00 (blank inactive), the color output equals the palette entry addressed by the pixel index.
- R2: With the command bit at 1, overlay codes 01, 10 and 11 output overlay registers 1, 2 and 3.
- R3: With the command bit at 0, overlay codes 00, 01, 10 and 11 output overlay registers 0, 1, 2 and 3.
- R4: While an overlay register is selected, the pixel index has no effect on the color output.
- R5: When `blank_n` is low, the next cycle shows `blank_o` at 1 and the color output at zero, whatever the pixel and overlay inputs are. Otherwise `blank_o` is 0.
- R6: `sync_o` equals the inverse of `sync_n` from the previous cycle, in every state of blank. Sync never changes the color output.
- R7: Every output reflects the inputs sampled at the previous rising clock edge, so the color, blank and sync outputs stay aligned.
- R8: A host write (`host_we`=1) stores `host_data` at the next edge. `host_ovl`=0 targets the palette entry at `host_addr`. `host_ovl`=1 targets the overlay register at `host_addr[1:0]`. A pixel read of the same entry in the same cycle returns the old value.
- R9: While `rst` is high, `blank_o` is 1, `sync_o` is 0 and the color output is zero. Reset also clears all overlay registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_idx | input | 8 | Palette index of the pixel |
| ovl_code | input | 2 | Overlay select code |
| blank_n | input | 1 | Active-low blank |
| sync_n | input | 1 | Active-low sync |
| pal_on_zero | input | 1 | Command bit: 1 means code 00 uses the palette |
| host_we | input | 1 | Host write strobe |
| host_ovl | input | 1 | Write target: 0 for the palette, 1 for an overlay register |
| host_addr | input | 8 | Write address |
| host_data | input | 24 | Write data |
| color_o | output | 24 | Selected color word |
| blank_o | output | 1 | Blank flag, active high |
| sync_o | output | 1 | Sync flag, active high |

## Verification
A corrupted palette entry or overlay register shows up on `color_o` the first cycle it is selected without blank. It does not show while that entry is not addressed, so the bench writes every entry and then reads each one back through the pixel path. A stale or misaligned pipeline register shows up as a color, blank or sync value offset by one cycle. The bench catches this at once because it compares all three outputs on every clock. An error in code-00 decoding appears only when the command bit is 0 together with code 00, so that case is driven on its own.

// File: rtl/pixsel_pkg.sv
package pixsel_pkg;

    localparam int N_OVL   = 4;
    localparam int OVL_W   = $clog2(N_OVL);

    typedef enum logic [1:0] {
        SRC_PAL   = 2'd0,
        SRC_OVL   = 2'd1,
        SRC_BLANK = 2'd2
    } src_e;

    typedef struct packed {
        src_e             src;
        logic [OVL_W-1:0] ovl;
    } sel_t;

    function automatic sel_t decode_sel(logic blank_n, logic pal_on_zero,
                                        logic [OVL_W-1:0] code);
        sel_t s;
        s.ovl = code;
        if (!blank_n)
            s.src = SRC_BLANK;
        else if (code == '0 && pal_on_zero)
            s.src = SRC_PAL;
        else
            s.src = SRC_OVL;
        return s;
    endfunction

endpackage

// File: rtl/pixsel_decode.sv
module pixsel_decode
    import pixsel_pkg::*;
(
    input  logic             blank_n,
    input  logic             pal_on_zero,
    input  logic [OVL_W-1:0] code,
    output sel_t             sel
);
    always_comb sel = decode_sel(blank_n, pal_on_zero, code);
endmodule

// File: rtl/pixsel_palram.sv
module pixsel_palram #(
    parameter int IDX_W   = 8,
    parameter int COLOR_W = 24
) (
    input  logic               clk,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [COLOR_W-1:0] wdata,
    input  logic [IDX_W-1:0]   raddr,
    output logic [COLOR_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [COLOR_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pixsel_ovlbank.sv
module pixsel_ovlbank
    import pixsel_pkg::*;
#(
    parameter int COLOR_W = 24
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [OVL_W-1:0]              waddr,
    input  logic [COLOR_W-1:0]            wdata,
    output logic [N_OVL-1:0][COLOR_W-1:0] regs
);
    for (genvar g = 0; g < N_OVL; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && waddr == OVL_W'(g))
                regs[g] <= wdata;
        end
    end
endmodule

// File: rtl/pixsel_top.sv
module pixsel_top
    import pixsel_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int COLOR_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   pix_idx,
    input  logic [1:0]         ovl_code,
    input  logic               blank_n,
    input  logic               sync_n,
    input  logic               pal_on_zero,
    input  logic               host_we,
    input  logic               host_ovl,
    input  logic [IDX_W-1:0]   host_addr,
    input  logic [COLOR_W-1:0] host_data,
    output logic [COLOR_W-1:0] color_o,
    output logic               blank_o,
    output logic               sync_o
);
    sel_t                          sel_d, sel_q;
    logic [N_OVL-1:0][COLOR_W-1:0] ovl_flat;
    logic [COLOR_W-1:0]            pal_q, ovl_q;
    logic                          sync_q;

    pixsel_decode u_dec (
        .blank_n     (blank_n),
        .pal_on_zero (pal_on_zero),
        .code        (ovl_code),
        .sel         (sel_d)
    );

    pixsel_palram #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) u_pal (
        .clk   (clk),
        .we    (host_we && !host_ovl),
        .waddr (host_addr),
        .wdata (host_data),
        .raddr (pix_idx),
        .rdata (pal_q)
    );

    pixsel_ovlbank #(.COLOR_W(COLOR_W)) u_ovl (
        .clk   (clk),
        .rst   (rst),
        .we    (host_we && host_ovl),
        .waddr (host_addr[OVL_W-1:0]),
        .wdata (host_data),
        .regs  (ovl_flat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '{src: SRC_BLANK, ovl: '0};
            ovl_q  <= '0;
            sync_q <= 1'b0;
        end else begin
            sel_q  <= sel_d;
            ovl_q  <= ovl_flat[sel_d.ovl];
            sync_q <= !sync_n;
        end
    end

    always_comb begin
        unique case (sel_q.src)
            SRC_PAL: color_o = pal_q;
            SRC_OVL: color_o = ovl_q;
            default: color_o = '0;
        endcase
    end

    assign blank_o = (sel_q.src == SRC_BLANK);
    assign sync_o  = sync_q;

endmodule

// File: rtl/pixsel_chk.sv
module pixsel_chk #(
    parameter int IDX_W   = 8,
    parameter int COLOR_W = 24
) (
    input logic                    clk,
    input logic                    rst,
    input logic [1:0]              ovl_code,
    input logic                    blank_n,
    input logic                    sync_n,
    input logic                    pal_on_zero,
    input logic                    host_we,
    input logic                    host_ovl,
    input logic [IDX_W-1:0]        host_addr,
    input logic [COLOR_W-1:0]      host_data,
    input logic [COLOR_W-1:0]      color_o,
    input logic                    blank_o,
    input logic                    sync_o,
    input logic [3:0][COLOR_W-1:0] ovl_flat
);
    assert_blank_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(blank_n)) |-> (blank_o && color_o == '0));

    assert_sync_pass_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (sync_o == !$past(sync_n)));

    assert_ovl_pick_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(blank_n) && !$past(pal_on_zero))
        |-> (color_o == $past(ovl_flat[ovl_code])));

    assert_host_ovl_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(host_we) && $past(host_ovl))
        |-> (ovl_flat[$past(host_addr[1:0])] == $past(host_data)));
endmodule

bind pixsel_top pixsel_chk #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ovl_code    (ovl_code),
    .blank_n     (blank_n),
    .sync_n      (sync_n),
    .pal_on_zero (pal_on_zero),
    .host_we     (host_we),
    .host_ovl    (host_ovl),
    .host_addr   (host_addr),
    .host_data   (host_data),
    .color_o     (color_o),
    .blank_o     (blank_o),
    .sync_o      (sync_o),
    .ovl_flat    (ovl_flat)
);

// File: tb/sim_pixsel_top.sv
module sim_pixsel_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pix_idx = '0;
    logic [1:0]  ovl_code = '0;
    logic        blank_n = 1'b0;
    logic        sync_n = 1'b1;
    logic        pal_on_zero = 1'b1;
    logic        host_we = 1'b0;
    logic        host_ovl = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [23:0] host_data = '0;
    logic [23:0] color_o;
    logic        blank_o, sync_o;

    always #2 clk = ~clk;

    pixsel_top u0 (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [23:0] m_pal [256];
    logic [23:0] m_ovl [4];
    bit          have_exp = 0;
    logic [23:0] e_color;
    logic        e_blank, e_sync;
    string       e_tag;

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare();
        if (!have_exp) return;
        chk({e_tag, " R7 color"}, color_o, e_color);
        chk({e_tag, " R5 blank_o"}, {23'd0, blank_o}, {23'd0, e_blank});
        chk({e_tag, " R6 sync_o"}, {23'd0, sync_o}, {23'd0, e_sync});
    endtask

    task automatic step(input logic [7:0] idx, input logic [1:0] code,
                        input logic bn, input logic sn, input logic cmd,
                        input logic we, input logic tgt, input logic [7:0] addr,
                        input logic [23:0] data, input string tag);
        @(negedge clk);
        compare();
        pix_idx = idx; ovl_code = code; blank_n = bn; sync_n = sn;
        pal_on_zero = cmd; host_we = we; host_ovl = tgt;
        host_addr = addr; host_data = data;
        e_sync = !sn;
        e_blank = !bn;
        if (!bn) e_color = '0;
        else if (code == 2'b00 && cmd) e_color = m_pal[idx];
        else e_color = m_ovl[code];
        e_tag = tag;
        have_exp = 1;
        if (we) begin
            if (tgt) m_ovl[addr[1:0]] = data;
            else m_pal[addr] = data;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_ovl[i] = '0;
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 color", color_o, 24'd0);
        chk("R9 blank_o", {23'd0, blank_o}, 24'd1);
        chk("R9 sync_o", {23'd0, sync_o}, 24'd0);
        @(negedge clk);
        rst = 1'b0;
        // R9: overlay registers cleared by reset
        for (int c = 0; c < 4; c++)
            step(8'(c * 37), 2'(c), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 24'd0, "R9 ovl clear");
        // R8/R5: load palette while blanked with random pixel inputs
        for (int a = 0; a < 256; a++)
            step(8'($urandom), 2'($urandom), 1'b0, 1'b1, 1'b1, 1'b1, 1'b0,
                 8'(a), 24'($urandom), "R8 R5 load");
        for (int c = 0; c < 4; c++)
            step(8'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'(c), 24'($urandom), "R8 ovl load");
        // R1: palette sweep
        for (int a = 0; a < 256; a++)
            step(8'(255 - a), 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 24'd0, "R1");
        // R2: command bit 1, overlay codes
        for (int c = 1; c < 4; c++)
            step(8'($urandom), 2'(c), 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 24'd0, "R2");
        // R3: command bit 0, all codes including 00
        for (int c = 0; c < 4; c++)
            step(8'($urandom), 2'(c), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 24'd0, "R3");
        // R4: index changes while an overlay is held
        for (int i = 0; i < 20; i++)
            step(8'($urandom), 2'(1 + i % 3), 1'b1, 1'b1, 1'(i % 2), 1'b0, 1'b0,
                 8'd0, 24'd0, "R4");
        // R6: sync toggling with and without blank
        for (int i = 0; i < 16; i++)
            step(8'($urandom), 2'($urandom), 1'(i[1]), 1'(i[0]), 1'(i[2]), 1'b0, 1'b0,
                 8'd0, 24'd0, "R6");
        // R8: same-cycle write and read of the same palette entry, then re-read
        step(8'd42, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd42, 24'hABCDEF, "R8 same-cycle pal");
        step(8'd42, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 24'd0, "R8 next pal");
        // R8: same-cycle write and read of a selected overlay register
        step(8'd0, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'd2, 24'h123456, "R8 same-cycle ovl");
        step(8'd0, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 24'd0, "R8 next ovl");
        // random mix of all inputs
        for (int i = 0; i < 400; i++)
            step(8'($urandom), 2'($urandom), 1'($urandom % 4 != 0), 1'($urandom),
                 1'($urandom), 1'($urandom % 3 == 0), 1'($urandom), 8'($urandom),
                 24'($urandom), "R1 R2 R3 R8 mix");
        step(8'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 24'd0, "R5 end");
        @(negedge clk);
        compare();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule